// File: doc/BRIEF.md
# Boot Vector Redirect Memory Decoder

This block turns the address and the active-low memory enable of a 16-bit minicomputer-style CPU bus into active-low chip selects for one RAM array and one ROM array. It also settles where the CPU finds its reset vectors. The CPU reads its workspace pointer at word 0000h and its first program counter at 0002h when it leaves reset. That low range also holds the interrupt and software-trap vectors, so it has to end up as RAM. The decoder keeps a one-shot boot flag that is set by reset and cleared by the first instruction fetch. While the flag is set, the decoder hands the vector fetch to ROM in one of two ways.

A parameter picks the scheme. In the LOAD scheme the memory map never changes. RAM stays at the bottom of the space and ROM stays at the top. The decoder holds the CPU's LOAD request low while the flag is set, so the CPU fetches a second vector pair from the top two words of the space (FFFCh and FFFEh at 16 bits). Those words are in ROM. In the overlay scheme the LOAD request stays idle. Instead, ROM also answers at the bottom of memory until the first instruction fetch, and after that RAM takes the bottom back.

Region sizes and the address width are parameters. The default is 32 KiB of RAM from address zero and 8 KiB of ROM at the top of a 64 KiB space. Addresses in the gap between the two regions select neither array.

Top module: `bootvec_mem_decode`

## Requirements
- R1: From the first clock edge at which `rst` is high, the boot flag is set. In the LOAD scheme `load_n` reads 0 after that edge.
- R2: The boot flag clears at a rising edge where `mem_en_n` is 0 and `iaq` is 1. In the LOAD scheme `load_n` reads 1 from that edge on, and stays 1 until the next reset, whatever `iaq` does.
- R3: An edge with `iaq` at 1 while `mem_en_n` is 1 leaves the boot flag unchanged. `load_n` stays 0 in the LOAD scheme, and the low ROM overlay stays active in the overlay scheme.
- R4: While `mem_en_n` is 1, both `ram_cs_n` and `rom_cs_n` are 1 at every address.
- R5: In the LOAD scheme, with `mem_en_n` at 0 and in either boot state, `ram_cs_n` is 0 exactly for addresses below RAM_BYTES. `rom_cs_n` is 0 exactly for addresses at or above 2^ADDR_W − ROM_BYTES.
- R6: In the overlay scheme, while the boot flag is set and `mem_en_n` is 0, addresses below ROM_BYTES assert `rom_cs_n` and not `ram_cs_n`. The top ROM region still asserts `rom_cs_n`. RAM addresses at or above ROM_BYTES still assert `ram_cs_n`.
- R7: In the overlay scheme, after the boot flag clears, the map is the same as the R5 map, and address 0 selects RAM.
- R8: With `mem_en_n` at 0, an address outside both regions leaves both selects at 1.
- R9: `ram_cs_n` and `rom_cs_n` are never 0 in the same cycle.
- R10: In the overlay scheme `load_n` is always 1.
- R11: In the LOAD scheme, the boot accesses to 0000h and 0002h select RAM while `load_n` is 0. The accesses to the top-minus-4 and top-minus-2 words then select ROM, with `load_n` still 0.
- R12: A reset issued after boot has completed sets the boot flag again. `load_n` returns to 0 in the LOAD scheme, and the low ROM overlay returns in the overlay scheme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous, active-high reset; sets the boot flag |
| addr | input | ADDR_W | CPU byte address |
| mem_en_n | input | 1 | Active-low memory cycle enable |
| iaq | input | 1 | Instruction-acquisition strobe; high during an opcode fetch |
| ram_cs_n | output | 1 | Active-low RAM chip select |
| rom_cs_n | output | 1 | Active-low ROM chip select |
| load_n | output | 1 | Active-low LOAD request to the CPU (LOAD scheme only) |

## Verification
The bench builds two copies side by side with a 10-bit address, 512 bytes of RAM and 128 bytes of ROM. One copy uses the LOAD scheme and the other uses the overlay scheme, and both see the same stimulus. This small space lets every address be swept in the boot state, after release, and with memory disabled. Each region edge, the gap, and the overlay edge at 128 are therefore all hit, and the expected selects are computed from address arithmetic. The scaled boot vectors sit at 3FCh and 3FEh. A second reset late in the run checks that the one-shot flag re-arms.

// File: rtl/bvd_pkg.sv
`timescale 1ns/1ps
package bvd_pkg;

    typedef enum logic {
        BOOT_BY_LOAD    = 1'b0,
        BOOT_BY_OVERLAY = 1'b1
    } boot_scheme_e;

    // Which address windows the current bus address falls into.
    typedef struct packed {
        logic ram;      // RAM region at the bottom
        logic rom_top;  // ROM region at the top
        logic rom_low;  // ROM-sized window at address zero (overlay use)
    } region_hits_t;

    // Decoded, active-high selects before output inversion.
    typedef struct packed {
        logic ram;
        logic rom;
    } sel_pair_t;

    function automatic int space_bytes(input int addr_w);
        return 1 << addr_w;
    endfunction

    function automatic int rom_base(input int addr_w, input int rom_bytes);
        return space_bytes(addr_w) - rom_bytes;
    endfunction

endpackage

// File: rtl/bootvec_state.sv
`timescale 1ns/1ps
// One-shot boot flag: set by reset, cleared by the first opcode fetch
// seen in a cycle with memory enabled.
module bootvec_state (
    input  logic clk,
    input  logic rst,
    input  logic mem_active,
    input  logic iaq,
    output logic booting
);

    always_ff @(posedge clk) begin
        if (rst) begin
            booting <= 1'b1;
        end else if (mem_active && iaq) begin
            booting <= 1'b0;
        end
    end

endmodule

// File: rtl/bootvec_window.sv
`timescale 1ns/1ps
// Half-open address window [BASE, BASE+SIZE).
module bootvec_window #(
    parameter int ADDR_W = 16,
    parameter int BASE   = 0,
    parameter int SIZE   = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + SIZE);

    logic [ADDR_W:0] wide_addr;

    always_comb begin
        wide_addr = {1'b0, addr};
        hit = (wide_addr >= LO) && (wide_addr < HI);
    end

endmodule

// File: rtl/bootvec_select.sv
`timescale 1ns/1ps
// Combines window hits, memory enable and boot state into selects.
module bootvec_select
    import bvd_pkg::*;
#(
    parameter boot_scheme_e SCHEME = BOOT_BY_LOAD
) (
    input  region_hits_t hits,
    input  logic         mem_active,
    input  logic         booting,
    output sel_pair_t    sel
);

    logic overlay_on;
    logic steal_low;

    always_comb begin
        overlay_on = (SCHEME == BOOT_BY_OVERLAY) && booting;
        steal_low  = overlay_on && hits.rom_low;
        // ROM wins at the bottom while the overlay is active.
        sel.rom = mem_active && (hits.rom_top || steal_low);
        sel.ram = mem_active && hits.ram && !steal_low;
    end

endmodule

// File: rtl/bootvec_mem_decode.sv
`timescale 1ns/1ps
module bootvec_mem_decode
    import bvd_pkg::*;
#(
    parameter int           ADDR_W    = 16,
    parameter int           RAM_BYTES = 32768,
    parameter int           ROM_BYTES = 8192,
    parameter boot_scheme_e SCHEME    = BOOT_BY_LOAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_en_n,
    input  logic              iaq,
    output logic              ram_cs_n,
    output logic              rom_cs_n,
    output logic              load_n
);

    localparam int ROM_BASE = rom_base(ADDR_W, ROM_BYTES);

    logic         mem_active;
    logic         booting;
    region_hits_t hits;
    sel_pair_t    sel;

    assign mem_active = ~mem_en_n;

    bootvec_state u_state (
        .clk       (clk),
        .rst       (rst),
        .mem_active(mem_active),
        .iaq       (iaq),
        .booting   (booting)
    );

    bootvec_window #(.ADDR_W(ADDR_W), .BASE(0), .SIZE(RAM_BYTES)) u_win_ram (
        .addr(addr),
        .hit (hits.ram)
    );

    bootvec_window #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .SIZE(ROM_BYTES)) u_win_rom_top (
        .addr(addr),
        .hit (hits.rom_top)
    );

    bootvec_window #(.ADDR_W(ADDR_W), .BASE(0), .SIZE(ROM_BYTES)) u_win_rom_low (
        .addr(addr),
        .hit (hits.rom_low)
    );

    bootvec_select #(.SCHEME(SCHEME)) u_select (
        .hits      (hits),
        .mem_active(mem_active),
        .booting   (booting),
        .sel       (sel)
    );

    assign ram_cs_n = ~sel.ram;
    assign rom_cs_n = ~sel.rom;

    generate
        if (SCHEME == BOOT_BY_LOAD) begin : g_load_req
            assign load_n = ~booting;
        end else begin : g_no_load_req
            assign load_n = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/bootvec_mem_decode_chk.sv
`timescale 1ns/1ps
module bootvec_mem_decode_chk
    import bvd_pkg::*;
#(
    parameter int           ADDR_W    = 16,
    parameter int           RAM_BYTES = 32768,
    parameter int           ROM_BYTES = 8192,
    parameter boot_scheme_e SCHEME    = BOOT_BY_LOAD
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_en_n,
    input logic              iaq,
    input logic              ram_cs_n,
    input logic              rom_cs_n,
    input logic              load_n
);

    localparam logic [ADDR_W:0] RAM_END   = (ADDR_W+1)'(RAM_BYTES);
    localparam logic [ADDR_W:0] ROM_START = (ADDR_W+1)'(rom_base(ADDR_W, ROM_BYTES));

    logic [ADDR_W:0] wa;
    assign wa = {1'b0, addr};

    a_r9_never_both: assert property (@(posedge clk) disable iff (rst)
        !(!ram_cs_n && !rom_cs_n));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        mem_en_n |-> (ram_cs_n && rom_cs_n));

    a_r8_gap_quiet: assert property (@(posedge clk) disable iff (rst)
        (wa >= RAM_END && wa < ROM_START) |-> (ram_cs_n && rom_cs_n));

    generate
        if (SCHEME == BOOT_BY_LOAD) begin : g_load_chk
            a_r1_load_on_reset: assert property (@(posedge clk)
                rst |=> !load_n);

            a_r2_load_release: assert property (@(posedge clk) disable iff (rst)
                (!load_n && !mem_en_n && iaq) |=> load_n);

            a_r2_load_stays_off: assert property (@(posedge clk) disable iff (rst)
                load_n |=> load_n);

            a_r3_load_holds: assert property (@(posedge clk) disable iff (rst)
                (!load_n && !(!mem_en_n && iaq)) |=> !load_n);

            a_r5_ram_bottom: assert property (@(posedge clk) disable iff (rst)
                (!mem_en_n && wa < RAM_END) |-> !ram_cs_n);

            a_r5_rom_top: assert property (@(posedge clk) disable iff (rst)
                (!mem_en_n && wa >= ROM_START) |-> !rom_cs_n);
        end else begin : g_overlay_chk
            a_r10_no_load_req: assert property (@(posedge clk) disable iff (rst)
                load_n);

            a_r6_rom_top_kept: assert property (@(posedge clk) disable iff (rst)
                (!mem_en_n && wa >= ROM_START) |-> !rom_cs_n);
        end
    endgenerate

endmodule

bind bootvec_mem_decode bootvec_mem_decode_chk #(
    .ADDR_W   (ADDR_W),
    .RAM_BYTES(RAM_BYTES),
    .ROM_BYTES(ROM_BYTES),
    .SCHEME   (SCHEME)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .mem_en_n(mem_en_n),
    .iaq     (iaq),
    .ram_cs_n(ram_cs_n),
    .rom_cs_n(rom_cs_n),
    .load_n  (load_n)
);

// File: tb/bootvec_mem_decode_tb.sv
`timescale 1ns/1ps
module bootvec_mem_decode_tb;

    localparam int AW    = 10;
    localparam int SPACE = 1 << AW;
    localparam int RAMB  = 512;
    localparam int ROMB  = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          mem_en_n = 1'b1;
    logic          iaq = 1'b0;

    logic ram_l, rom_l, ld_l;
    logic ram_o, rom_o, ld_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  model_boot = 1'b1;

    always #5 clk = ~clk;

    bootvec_mem_decode #(
        .ADDR_W(AW), .RAM_BYTES(RAMB), .ROM_BYTES(ROMB),
        .SCHEME(bvd_pkg::BOOT_BY_LOAD)
    ) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .mem_en_n(mem_en_n), .iaq(iaq),
        .ram_cs_n(ram_l), .rom_cs_n(rom_l), .load_n(ld_l)
    );

    bootvec_mem_decode #(
        .ADDR_W(AW), .RAM_BYTES(RAMB), .ROM_BYTES(ROMB),
        .SCHEME(bvd_pkg::BOOT_BY_OVERLAY)
    ) u_dut_ovl (
        .clk(clk), .rst(rst), .addr(addr), .mem_en_n(mem_en_n), .iaq(iaq),
        .ram_cs_n(ram_o), .rom_cs_n(rom_o), .load_n(ld_o)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s addr=%0h: got %b expected %b", req, what, addr, got, exp);
        end
    endtask

    // Expected active-low selects from the address map arithmetic.
    task automatic expect_cs(input int a, input bit men, input bit boot, input bit ovl,
                             output logic ram_n, output logic rom_n);
        bit in_ram, in_top, in_low, steal;
        in_ram = (a < RAMB);
        in_top = (a >= SPACE - ROMB);
        in_low = (a < ROMB);
        steal  = ovl && boot && in_low;
        rom_n  = !(!men && (in_top || steal));
        ram_n  = !(!men && in_ram && !steal);
    endtask

    task automatic step(input int a, input bit men, input bit iq, input string req);
        logic er, eo;
        @(negedge clk);
        addr = AW'(a); mem_en_n = men; iaq = iq;
        #1;
        expect_cs(a, men, model_boot, 1'b0, er, eo);
        chk(ram_l, er, req, "load-scheme ram_cs_n");
        chk(rom_l, eo, req, "load-scheme rom_cs_n");
        expect_cs(a, men, model_boot, 1'b1, er, eo);
        chk(ram_o, er, req, "overlay ram_cs_n");
        chk(rom_o, eo, req, "overlay rom_cs_n");
        chk(ld_l, !model_boot, req, "load-scheme load_n");
        chk(ld_o, 1'b1, "R10", "overlay load_n");
        chk(!(!ram_l && !rom_l), 1'b1, "R9", "load-scheme exclusive");
        chk(!(!ram_o && !rom_o), 1'b1, "R9", "overlay exclusive");
        if (!men && iq) model_boot = 1'b0;
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1; mem_en_n = 1'b1; iaq = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_boot = 1'b1;
        #1;
        chk(ld_l, 1'b0, req, "load_n after reset");
        chk(ld_o, 1'b1, "R10", "overlay load_n after reset");
        chk(ram_l & rom_l & ram_o & rom_o, 1'b1, "R4", "selects idle in reset");
    endtask

    initial begin
        // R1: reset state
        do_reset("R1");

        // R11: boot vector sequence, 0000, 0002, top-4, top-2
        step(0, 1'b0, 1'b0, "R11");
        step(2, 1'b0, 1'b0, "R11");
        step(SPACE - 4, 1'b0, 1'b0, "R11");
        step(SPACE - 2, 1'b0, 1'b0, "R11");

        // R3: strobe with memory disabled does not release
        step(SPACE - 2, 1'b1, 1'b1, "R3");
        step(0, 1'b0, 1'b0, "R3");
        step(ROMB - 2, 1'b0, 1'b0, "R3");

        // R5/R6/R8 sweep in the boot state
        for (int a = 0; a < SPACE; a++) step(a, 1'b0, 1'b0, "R5/R6/R8");

        // R4 sweep with memory disabled
        for (int a = 0; a < SPACE; a++) step(a, 1'b1, 1'b0, "R4");

        // R2: first opcode fetch from ROM releases the boot state
        step(SPACE - ROMB, 1'b0, 1'b1, "R2");
        step(0, 1'b0, 1'b0, "R2");

        // R5/R7/R8 sweep after release
        for (int a = 0; a < SPACE; a++) step(a, 1'b0, 1'b0, "R5/R7/R8");

        // R2: later fetches keep LOAD released
        for (int a = 0; a < 16; a++) step(a * 2, 1'b0, a[0], "R2");

        // R12: second reset mid-run re-arms the boot state
        do_reset("R12");
        step(0, 1'b0, 1'b0, "R12");
        step(ROMB - 1, 1'b0, 1'b0, "R12");
        step(ROMB, 1'b0, 1'b0, "R12");
        step(SPACE - 2, 1'b0, 1'b1, "R12");
        step(0, 1'b0, 1'b0, "R7");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (R1..R12 run): got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule